// File: doc/BRIEF.md
# NAND Page Program Sequencer

This block sits on the host side of a large-page NAND flash device that has an 8-bit multiplexed bus. It turns a single page-program request into the full train of bus cycles the device needs. A request names a block, a page, a starting column and a byte count. The sequencer first checks that the request fits inside one page. It then issues the program-setup command and packs the location into address cycles with a fixed bit layout. After that it streams the payload bytes, pulling one byte from the host at a time, and issues the program-confirm command.

While the device is busy, the sequencer sends one read-status command and then keeps reading the status byte until the device reports completion. It closes the operation with a one-cycle result pulse that carries a pass, fail or reject code. The number of address cycles is a build parameter: 4 cycles for devices with 1024 blocks, 5 for larger ones. The width of the write and read strobes is also a parameter.

Top module: `nand_page_writer`

## Requirements
- R1: The first bus cycle of an accepted request is a command cycle carrying 80h. The cycle that follows the last data byte is a command cycle carrying 10h. Every command cycle has the command latch high and the address latch low.
- R2: With 5 address cycles, the address bytes go out in this order:
  - column[7:0]
  - {0000, column[11:8]}
  - {block[1:0], page[5:0]}
  - block[9:2]
  - {00000, block[12:10]}

  For example, block 2047, page 60, column 2000 gives D0h 07h FCh FFh 01h, and block 20h, page 19h, column 0 gives 00h 00h 19h 08h 00h.
- R3: Spare-area columns 2048 to 2111 are encoded as ordinary column numbers. Column 2103 gives first address bytes 37h and 08h. A request whose column plus length equals exactly 2112 is accepted.
- R4: Exactly as many data cycles as the requested length are issued. The bytes go out in the order they were pulled, with both latches low. One pull pulse precedes each byte.
- R5: After the confirm command, the only command issued is 70h, and it is issued once. It is followed by read cycles in which the I/O bus is not driven. Status reads repeat until status bit 6 reads 1. With N busy reads, N+1 reads are made in total.
- R6: Completion is a one-cycle result pulse. The code is 0 (pass) when status bit 0 is 0 and 1 (fail) when it is 1.
- R7: A request is rejected with code 2 and no strobe activity at all if any of these holds: its length is 0, its column plus length exceeds 2112, or its page is 64 or more.
- R8: Every write strobe stays low for exactly STROBE_W clocks. The command latch and address latch are never high together.
- R9: After reset, both strobes are high, both latches are low, the block is ready, and no result pulse is present.
- R10: While an operation is in progress the ready output is low, and a request input held high is ignored until the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken when reqReady is high |
| reqReady | output | 1 | Block idle and able to take a request |
| reqBlock | input | BLK_W | Block number (13 bits for 5 cycles, 10 bits for 4) |
| reqPage | input | 8 | Page number within block |
| reqCol | input | 12 | Starting column, 0 to 2111 |
| reqLen | input | 12 | Payload length in bytes |
| dataIn | input | 8 | Next payload byte from the host |
| dataPull | output | 1 | dataIn is captured at the coming clock edge |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandIoOut | output | 8 | Bus value driven toward the device |
| nandIoOe | output | 1 | Output enable for nandIoOut |
| nandIoIn | input | 8 | Bus value returned by the device |
| doneValid | output | 1 | One-cycle result pulse |
| doneCode | output | 2 | 0 pass, 1 fail, 2 rejected |

## Verification
Two events can land on the same clock edge.

- **End of addressing and first payload byte.** The edge that ends the last address cycle is also the edge that pulls the first payload byte. One-byte and full-2112-byte requests both provoke this. It is judged by the data-cycle count and by the value of the first byte the device model records.
- **Status capture and completion.** When the device model reports ready on the very first read, the same poll cycle both captures the status and decides the result. The read count must then be exactly one, and the code must follow bit 0.

A request held high across a whole operation makes the idle return and the request meet at the same edge. The check is that only one command train appears.

// File: rtl/nps_pkg.sv
package nps_pkg;

  localparam logic [7:0] OP_SETUP   = 8'h80;
  localparam logic [7:0] OP_CONFIRM = 8'h10;
  localparam logic [7:0] OP_STATUS  = 8'h70;

  localparam logic [1:0] RES_PASS   = 2'd0;
  localparam logic [1:0] RES_FAIL   = 2'd1;
  localparam logic [1:0] RES_REJECT = 2'd2;

  // which byte source the datapath puts on the bus
  typedef enum logic [2:0] {
    BUS_IDLE,
    BUS_SETUP,
    BUS_ADDR,
    BUS_DATA,
    BUS_CONFIRM,
    BUS_STATUS
  } busSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    latchReq;
    logic    addrStep;
    logic    pullData;
    logic    grabStatus;
    busSel_e sel;
  } dpCtl_t;

endpackage

// File: rtl/nps_datapath.sv
module nps_datapath
  import nps_pkg::*;
#(
  parameter int ADDR_CYCLES = 5,
  parameter int BLK_W       = 13,
  parameter int PAGE_BYTES  = 2112,
  parameter int PAGES       = 64,
  parameter int CNT_W       = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [BLK_W-1:0] reqBlock,
  input  logic [7:0]       reqPage,
  input  logic [CNT_W-1:0] reqCol,
  input  logic [CNT_W-1:0] reqLen,
  input  logic [7:0]       dataIn,
  input  logic [7:0]       ioIn,
  output logic             reqBad,
  output logic             addrLast,
  output logic             dataLast,
  output logic             statReady,
  output logic             statFail,
  output logic [7:0]       ioOut
);

  localparam int ACW     = $clog2(ADDR_CYCLES);
  localparam int PG_W    = $clog2(PAGES);
  localparam int HI_BITS = BLK_W - 10;

  logic [BLK_W-1:0] blkReg;
  logic [PG_W-1:0]  pageReg;
  logic [CNT_W-1:0] colReg;
  logic [CNT_W-1:0] remaining;
  logic [ACW-1:0]   addrIdx;
  logic [7:0]       dataReg;
  logic [7:0]       statReg;
  logic [CNT_W:0]   endCol;
  logic [7:0]       hiByte;
  logic [7:0]       addrByte;

  // request screening
  assign endCol = {1'b0, reqCol} + {1'b0, reqLen};
  assign reqBad = (reqLen == '0) ||
                  (endCol > (CNT_W+1)'(PAGE_BYTES)) ||
                  ({24'd0, reqPage} >= 32'(PAGES));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blkReg    <= '0;
      pageReg   <= '0;
      colReg    <= '0;
      remaining <= '0;
      addrIdx   <= '0;
      dataReg   <= '0;
      statReg   <= '0;
    end else begin
      if (ctl.latchReq) begin
        blkReg    <= reqBlock;
        pageReg   <= reqPage[PG_W-1:0];
        colReg    <= reqCol;
        remaining <= reqLen;
        addrIdx   <= '0;
        statReg   <= '0;
      end
      if (ctl.addrStep) addrIdx <= addrIdx + 1'b1;
      if (ctl.pullData) begin
        dataReg   <= dataIn;
        remaining <= remaining - 1'b1;
      end
      if (ctl.grabStatus) statReg <= ioIn;
    end
  end

  // upper block bits only exist for the longer address train
  generate
    if (ADDR_CYCLES > 4) begin : g_hi
      assign hiByte = {{(8-HI_BITS){1'b0}}, blkReg[BLK_W-1:10]};
    end else begin : g_nohi
      assign hiByte = 8'h00;
    end
  endgenerate

  always_comb begin
    case (addrIdx)
      ACW'(0): addrByte = colReg[7:0];
      ACW'(1): addrByte = {4'b0000, colReg[11:8]};
      ACW'(2): addrByte = {blkReg[1:0], pageReg};
      ACW'(3): addrByte = blkReg[9:2];
      default: addrByte = hiByte;
    endcase
  end

  always_comb begin
    case (ctl.sel)
      BUS_SETUP:   ioOut = OP_SETUP;
      BUS_ADDR:    ioOut = addrByte;
      BUS_DATA:    ioOut = dataReg;
      BUS_CONFIRM: ioOut = OP_CONFIRM;
      BUS_STATUS:  ioOut = OP_STATUS;
      default:     ioOut = 8'h00;
    endcase
  end

  assign addrLast  = (addrIdx == ACW'(ADDR_CYCLES - 1));
  assign dataLast  = (remaining == '0);
  assign statReady = statReg[6];
  assign statFail  = statReg[0];

endmodule

// File: rtl/nps_ctrl.sv
module nps_ctrl
  import nps_pkg::*;
#(
  parameter int STROBE_W = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqBad,
  input  logic       addrLast,
  input  logic       dataLast,
  input  logic       statReady,
  input  logic       statFail,
  output dpCtl_t     ctl,
  output logic       reqReady,
  output logic       cle,
  output logic       ale,
  output logic       weN,
  output logic       reN,
  output logic       ioOe,
  output logic       doneValid,
  output logic [1:0] doneCode
);

  localparam int PH_LAST = 2 * STROBE_W - 1;
  localparam int PH_W    = (PH_LAST > 0) ? $clog2(PH_LAST + 1) : 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_ADDR, ST_DATA, ST_CONF, ST_STCMD, ST_POLL, ST_DONE
  } state_e;

  state_e          state, nextState;
  logic [PH_W-1:0] ph;
  logic [1:0]      code, nextCode;
  logic            phEnd, lowPhase, writeState;

  assign phEnd      = (ph == PH_W'(PH_LAST));
  assign lowPhase   = (ph < PH_W'(STROBE_W));
  assign writeState = (state == ST_SETUP) || (state == ST_ADDR) || (state == ST_DATA) ||
                      (state == ST_CONF)  || (state == ST_STCMD);

  always_comb begin
    nextState = state;
    nextCode  = code;
    ctl       = '0;
    case (state)
      ST_SETUP: ctl.sel = BUS_SETUP;
      ST_ADDR:  ctl.sel = BUS_ADDR;
      ST_DATA:  ctl.sel = BUS_DATA;
      ST_CONF:  ctl.sel = BUS_CONFIRM;
      ST_STCMD: ctl.sel = BUS_STATUS;
      default:  ctl.sel = BUS_IDLE;
    endcase
    case (state)
      ST_IDLE: if (reqValid) begin
        if (reqBad) begin
          nextState = ST_DONE;
          nextCode  = RES_REJECT;
        end else begin
          ctl.latchReq = 1'b1;
          nextState    = ST_SETUP;
        end
      end
      ST_SETUP: if (phEnd) nextState = ST_ADDR;
      ST_ADDR: if (phEnd) begin
        if (addrLast) begin
          nextState    = ST_DATA;
          ctl.pullData = 1'b1;
        end else begin
          ctl.addrStep = 1'b1;
        end
      end
      ST_DATA: if (phEnd) begin
        if (dataLast) nextState = ST_CONF;
        else          ctl.pullData = 1'b1;
      end
      ST_CONF:  if (phEnd) nextState = ST_STCMD;
      ST_STCMD: if (phEnd) nextState = ST_POLL;
      ST_POLL: begin
        if (ph == PH_W'(STROBE_W - 1)) ctl.grabStatus = 1'b1;
        if (phEnd && statReady) begin
          nextState = ST_DONE;
          nextCode  = statFail ? RES_FAIL : RES_PASS;
        end
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      ph    <= '0;
      code  <= RES_PASS;
    end else begin
      state <= nextState;
      code  <= nextCode;
      if (writeState || state == ST_POLL) ph <= phEnd ? '0 : ph + 1'b1;
      else                                ph <= '0;
    end
  end

  assign reqReady  = (state == ST_IDLE);
  assign cle       = (state == ST_SETUP) || (state == ST_CONF) || (state == ST_STCMD);
  assign ale       = (state == ST_ADDR);
  assign weN       = !(writeState && lowPhase);
  assign reN       = !((state == ST_POLL) && lowPhase);
  assign ioOe      = writeState;
  assign doneValid = (state == ST_DONE);
  assign doneCode  = code;

endmodule

// File: rtl/nand_page_writer.sv
module nand_page_writer
  import nps_pkg::*;
#(
  parameter  int ADDR_CYCLES = 5,
  parameter  int STROBE_W    = 2,
  parameter  int PAGE_BYTES  = 2112,
  localparam int BLK_W       = (ADDR_CYCLES > 4) ? 13 : 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [BLK_W-1:0] reqBlock,
  input  logic [7:0]       reqPage,
  input  logic [11:0]      reqCol,
  input  logic [11:0]      reqLen,
  input  logic [7:0]       dataIn,
  output logic             dataPull,
  output logic             nandCle,
  output logic             nandAle,
  output logic             nandWeN,
  output logic             nandReN,
  output logic [7:0]       nandIoOut,
  output logic             nandIoOe,
  input  logic [7:0]       nandIoIn,
  output logic             doneValid,
  output logic [1:0]       doneCode
);

  dpCtl_t ctl;
  logic   reqBad, addrLast, dataLast, statReady, statFail;

  nps_ctrl #(.STROBE_W(STROBE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBad(reqBad),
    .addrLast(addrLast), .dataLast(dataLast), .statReady(statReady),
    .statFail(statFail), .ctl(ctl), .reqReady(reqReady), .cle(nandCle),
    .ale(nandAle), .weN(nandWeN), .reN(nandReN), .ioOe(nandIoOe),
    .doneValid(doneValid), .doneCode(doneCode)
  );

  nps_datapath #(
    .ADDR_CYCLES(ADDR_CYCLES), .BLK_W(BLK_W), .PAGE_BYTES(PAGE_BYTES),
    .PAGES(64), .CNT_W(12)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqBlock(reqBlock), .reqPage(reqPage),
    .reqCol(reqCol), .reqLen(reqLen), .dataIn(dataIn), .ioIn(nandIoIn),
    .reqBad(reqBad), .addrLast(addrLast), .dataLast(dataLast),
    .statReady(statReady), .statFail(statFail), .ioOut(nandIoOut)
  );

  assign dataPull = ctl.pullData;

endmodule

// File: rtl/nps_checker.sv
module nps_checker #(
  parameter int STROBE_W = 2
) (
  input logic       clk,
  input logic       rstN,
  input logic       cle,
  input logic       ale,
  input logic       weN,
  input logic       reN,
  input logic       ioOe,
  input logic [7:0] ioOut,
  input logic       reqReady,
  input logic       doneValid,
  input logic [1:0] doneCode
);

  logic [15:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              lowCnt <= '0;
    else if (weN)           lowCnt <= '0;
    else if (lowCnt != '1)  lowCnt <= lowCnt + 1'b1;
  end

  // R8
  cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(cle && ale));
  // R8
  we_short_chk: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> (lowCnt < 16'(STROBE_W)));
  // R8
  we_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(weN) |-> (lowCnt == 16'(STROBE_W)));
  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(!weN && !reN));
  // R5
  read_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN) !reN |-> !ioOe);
  // R1
  cmd_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cle && !weN) |-> (ioOut == 8'h80 || ioOut == 8'h10 || ioOut == 8'h70));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) doneValid |=> !doneValid);
  // R6
  code_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (doneCode != 2'd3));
  // R10
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!weN || !reN) |-> !reqReady);
  // R7
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneCode == 2'd2) |-> $past(reqReady));

endmodule

bind nand_page_writer nps_checker #(.STROBE_W(STROBE_W)) u_chk (
  .clk(clk), .rstN(rstN), .cle(nandCle), .ale(nandAle), .weN(nandWeN),
  .reN(nandReN), .ioOe(nandIoOe), .ioOut(nandIoOut), .reqReady(reqReady),
  .doneValid(doneValid), .doneCode(doneCode)
);

// File: tb/nand_page_writer_bench.sv
module nand_page_writer_bench;

  localparam int STROBE_W = 2;
  localparam int BLK_W    = 13;
  localparam int NVEC     = 8;

  typedef struct packed {
    logic [12:0] blk;
    logic [7:0]  page;
    logic [11:0] col;
    logic [11:0] len;
    logic [3:0]  busy;
    logic        failBit;
    logic [1:0]  expCode;
    logic [39:0] expAddr;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{13'd2047, 8'd60, 12'd2000, 12'd8,    4'd3, 1'b0, 2'd0, 40'hD0_07_FC_FF_01},
    '{13'h20,   8'h19, 12'd0,    12'd5,    4'd0, 1'b1, 2'd1, 40'h00_00_19_08_00},
    '{13'd5,    8'd1,  12'd2103, 12'd9,    4'd1, 1'b0, 2'd0, 40'h37_08_41_01_00},
    '{13'd0,    8'd64, 12'd0,    12'd1,    4'd0, 1'b0, 2'd2, 40'h0},
    '{13'd0,    8'd0,  12'd2100, 12'd13,   4'd0, 1'b0, 2'd2, 40'h0},
    '{13'd0,    8'd0,  12'd10,   12'd0,    4'd0, 1'b0, 2'd2, 40'h0},
    '{13'd8191, 8'd63, 12'd0,    12'd1,    4'd2, 1'b0, 2'd0, 40'h00_00_FF_FF_07},
    '{13'd1,    8'd2,  12'd0,    12'd2112, 4'd1, 1'b0, 2'd0, 40'h00_00_42_00_00}
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             reqValid = 1'b0;
  logic             reqReady;
  logic [BLK_W-1:0] reqBlock = '0;
  logic [7:0]       reqPage = '0;
  logic [11:0]      reqCol = '0;
  logic [11:0]      reqLen = '0;
  logic [7:0]       dataIn;
  logic             dataPull;
  logic             nandCle, nandAle, nandWeN, nandReN, nandIoOe;
  logic [7:0]       nandIoOut, nandIoIn;
  logic             doneValid;
  logic [1:0]       doneCode;

  always #4 clk = ~clk;

  nand_page_writer #(.ADDR_CYCLES(5), .STROBE_W(STROBE_W)) u_nand_page_writer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqBlock(reqBlock), .reqPage(reqPage), .reqCol(reqCol), .reqLen(reqLen),
    .dataIn(dataIn), .dataPull(dataPull), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandReN(nandReN), .nandIoOut(nandIoOut),
    .nandIoOe(nandIoOe), .nandIoIn(nandIoIn), .doneValid(doneValid),
    .doneCode(doneCode)
  );

  int nChecks = 0, nFail = 0, cyc = 0;
  int nCmd, nAddr, nData, nReads, dataErr, orderErr, widthErr, lowLen;
  int busyLeft = 0, curBusy = 0, curVec = 0, pullIdx = 0;
  bit confSeen, gotDone, pullPending, curFail;
  logic [1:0] gotCode;
  logic [7:0] cmdLog [8];
  logic [7:0] addrLog [8];
  logic prevWe = 1'b1, prevRe = 1'b1;

  function automatic logic [7:0] pat(int v, int i);
    return 8'(i * 7 + v * 13 + 3);
  endfunction

  assign dataIn   = pat(curVec, pullIdx);
  assign nandIoIn = (busyLeft > 0) ? 8'h00 : {1'b0, 1'b1, 5'b0, curFail};

  // device model: records each completed bus cycle at the write strobe rise
  always @(negedge clk) begin
    if (pullPending) pullIdx++;
    pullPending = dataPull;
    if (!nandWeN) lowLen++;
    if (nandWeN && !prevWe) begin
      if (lowLen != STROBE_W) widthErr++;
      if (nandCle && !nandAle) begin
        if (nCmd < 8) cmdLog[nCmd] = nandIoOut;
        nCmd++;
        if (confSeen && nandIoOut != 8'h70) orderErr++;
        if (nandIoOut == 8'h10) begin confSeen = 1'b1; busyLeft = curBusy; end
      end else if (nandAle && !nandCle) begin
        if (confSeen) orderErr++;
        if (nAddr < 8) addrLog[nAddr] = nandIoOut;
        nAddr++;
      end else if (!nandCle && !nandAle) begin
        if (confSeen) orderErr++;
        if (nandIoOut != pat(curVec, nData)) dataErr++;
        nData++;
      end else orderErr++;
      lowLen = 0;
    end
    if (nandReN && !prevRe) begin
      nReads++;
      if (busyLeft > 0) busyLeft--;
    end
    if (doneValid) begin gotDone = 1'b1; gotCode = doneCode; end
    prevWe = nandWeN;
    prevRe = nandReN;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFail++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearLogs();
    nCmd = 0; nAddr = 0; nData = 0; nReads = 0;
    dataErr = 0; orderErr = 0; widthErr = 0; lowLen = 0;
    confSeen = 1'b0; gotDone = 1'b0; gotCode = 2'd3;
  endtask

  task automatic runVec(int v, bit hold);
    int t;
    @(negedge clk); #1;
    clearLogs();
    curVec = v; curBusy = int'(VECS[v].busy); curFail = VECS[v].failBit;
    pullIdx = 0; pullPending = 1'b0;
    reqBlock = VECS[v].blk; reqPage = VECS[v].page;
    reqCol = VECS[v].col; reqLen = VECS[v].len;
    reqValid = 1'b1;
    if (!hold) begin @(negedge clk); #1; reqValid = 1'b0; end
    t = 0;
    while (!gotDone && t < 20000) begin @(negedge clk); #1; t++; end
    reqValid = 1'b0;
    chk(gotDone, "R6", "result pulse seen", int'(gotDone), 1);
    chk(gotCode == VECS[v].expCode, (VECS[v].expCode == 2'd2) ? "R7" : "R6",
        "result code", int'(gotCode), int'(VECS[v].expCode));
    if (VECS[v].expCode == 2'd2) begin
      chk(nCmd + nAddr + nData + nReads == 0, "R7", "bus cycles on reject",
          nCmd + nAddr + nData + nReads, 0);
    end else begin
      chk(nCmd == 3, "R5", "command count", nCmd, 3);
      chk(cmdLog[0] == 8'h80, "R1", "setup opcode", int'(cmdLog[0]), 8'h80);
      chk(cmdLog[1] == 8'h10, "R1", "confirm opcode", int'(cmdLog[1]), 8'h10);
      chk(cmdLog[2] == 8'h70, "R5", "status opcode", int'(cmdLog[2]), 8'h70);
      chk(nAddr == 5, "R2", "address cycles", nAddr, 5);
      for (int k = 0; k < 5; k++) begin
        logic [7:0] e;
        e = VECS[v].expAddr[39 - 8*k -: 8];
        chk(addrLog[k] == e, (v == 2) ? "R3" : "R2", "address byte", int'(addrLog[k]), int'(e));
      end
      chk(nData == int'(VECS[v].len), "R4", "data cycles", nData, int'(VECS[v].len));
      chk(dataErr == 0, "R4", "data byte mismatches", dataErr, 0);
      chk(nReads == curBusy + 1, "R5", "status reads", nReads, curBusy + 1);
      chk(orderErr == 0, "R8", "latch/order violations", orderErr, 0);
      chk(widthErr == 0, "R8", "strobe width errors", widthErr, 0);
    end
  endtask

  initial begin
    clearLogs();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    // R9 reset state
    chk(nandWeN == 1'b1, "R9", "write strobe after reset", int'(nandWeN), 1);
    chk(nandReN == 1'b1, "R9", "read strobe after reset", int'(nandReN), 1);
    chk(!nandCle && !nandAle, "R9", "latches after reset", int'({nandCle, nandAle}), 0);
    chk(reqReady == 1'b1, "R9", "ready after reset", int'(reqReady), 1);
    chk(doneValid == 1'b0, "R9", "result pulse after reset", int'(doneValid), 0);

    for (int v = 0; v < NVEC; v++) runVec(v, 1'b0);

    // R10: request held high through a whole operation gives one operation only
    runVec(2, 1'b1);
    repeat (20) @(negedge clk);
    #1;
    chk(nCmd == 3, "R10", "commands after held request", nCmd, 3);
    chk(nData == 9, "R10", "data cycles after held request", nData, 9);
    chk(reqReady == 1'b1, "R10", "ready after held request", int'(reqReady), 1);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule